// File: doc/BRIEF.md
# Locked Watchdog Timer with Bus Slave Port

This block counts down from a software-written reload value on its own counter clock. When the count runs out for the first time it raises a pending interrupt. When it runs out a second time while that interrupt is still pending and reset requests are enabled, it raises a reset request. The reset request stays high until the counter-side reset. Software services the watchdog by writing the clear register. That write drops the pending interrupt and restarts the count from the reload value.

Register writes pass through a write guard. Writing the 32-bit key 0x1ACCE551 to the lock register opens the guard. Writing any other value closes it. While the guard is closed, writes to every other register are discarded, and all registers can still be read. A test mode hands both outputs over to a register that software writes, so the interrupt and reset wiring can be checked without waiting for the count.

The bus side and the counter side use separate clocks and separate active-low resets. Three things cross from the bus side to the counter side through two-flop synchronizers: the control bits, a toggle for each reload write and a toggle for each clear write. The raw status crosses back the same way.

The counter side is a four-state machine:
- `WD_IDLE`: counting is off and nothing is pending.
- `WD_ARMED`: counting with nothing pending.
- `WD_EXPIRED`: the interrupt is pending.
- `WD_TRIPPED`: the reset request is high.

Its transitions are:
- IDLE→ARMED when interrupt enable goes to 1.
- IDLE→EXPIRED or ARMED→EXPIRED when the count runs out.
- ARMED→IDLE when interrupt enable goes to 0.
- EXPIRED→ARMED or EXPIRED→IDLE on a clear write, depending on interrupt enable.
- EXPIRED→TRIPPED when the count runs out again with reset enable at 1.
- TRIPPED has no exit except the counter reset.

Top module: `apb_wdog`

## Requirements
- R1: After both resets, control reads 0, reload reads 0xFFFFFFFF, the lock register reads 0 (unlocked), and `wdog_irq` and `wdog_rst` are low.
- R2: The register map is: reload at 0x00, control at 0x04 (bit 0 interrupt enable, bit 1 reset enable), clear at 0x08 (write only), raw status at 0x0C (bit 0), masked status at 0x10 (bit 0), lock at 0x14, test control at 0x18 (bit 0), test output at 0x1C (bit 0 interrupt, bit 1 reset). The control bits and the reload value read back as written.
- R3: While interrupt enable is 1, the counter drops by one each counter-clock cycle. A reload write of N makes raw status rise about N counter cycles later, never within half of N, and `wdog_irq` goes high.
- R4: While interrupt enable is 0, the counter holds and raw status stays 0.
- R5: Masked status equals raw status AND interrupt enable. Outside test mode, `wdog_irq` follows masked status, and clearing the enable drops it while raw status stays 1.
- R6: A write of any value to the clear register drops the pending interrupt and reloads the counter, so the interrupt returns after one more full period.
- R7: A second run-out while the interrupt is pending and reset enable is 1 raises `wdog_rst`. It stays high through clear writes until the counter reset.
- R8: With reset enable at 0, repeated run-outs leave `wdog_rst` low.
- R9: Writing 0x1ACCE551 to the lock register unlocks it and any other value locks it. The lock register reads 1 when locked and 0 when unlocked.
- R10: While locked, writes to the reload and control registers have no effect, and reads still return the held values.
- R11: With test control bit 0 set, `wdog_irq` and `wdog_rst` follow test output bits 0 and 1.
- R12: Clearing test control bit 0 returns both outputs to the counter logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| wclk | input | 1 | Counter clock |
| wresetn | input | 1 | Counter reset, active low |
| wdog_irq | output | 1 | Level interrupt |
| wdog_rst | output | 1 | Reset request |

## Verification
The counting function is driven with three kinds of input:
- A reload value with counting enabled and nothing serviced. This separates a count that runs out on time from one that runs out early or never.
- The same reload with interrupt enable held at 0. This shows whether the counter truly holds.
- A pending interrupt followed by a clear write. This separates a true reload-on-clear from a flag that is merely dropped.

Run-outs with reset enable at 1 and at 0 distinguish the path to the reset request from a plain repeated interrupt. A locked-then-unlocked write sequence distinguishes discarded writes from accepted ones, and shows that the key value is honoured only exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned DATA_W = 32;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

    localparam int unsigned OFS_LOAD = 'h00;
    localparam int unsigned OFS_CTRL = 'h04;
    localparam int unsigned OFS_CLR  = 'h08;
    localparam int unsigned OFS_RAW  = 'h0C;
    localparam int unsigned OFS_MASK = 'h10;
    localparam int unsigned OFS_LOCK = 'h14;
    localparam int unsigned OFS_TCTL = 'h18;
    localparam int unsigned OFS_TOUT = 'h1C;

    typedef enum logic [1:0] {
        WD_IDLE,
        WD_ARMED,
        WD_EXPIRED,
        WD_TRIPPED
    } wd_state_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              raw_b,
    output logic [1:0]        ctrl_o,
    output logic [DATA_W-1:0] load_o,
    output logic              load_tgl_o,
    output logic              clr_tgl_o,
    output logic              tmode_o,
    output logic [1:0]        tout_o,
    output logic              locked_o
);
    logic wr;
    assign wr = psel && penable && pwrite;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            ctrl_o     <= '0;
            load_o     <= '1;
            load_tgl_o <= 1'b0;
            clr_tgl_o  <= 1'b0;
            tmode_o    <= 1'b0;
            tout_o     <= '0;
            locked_o   <= 1'b0;
        end else if (wr) begin
            if (paddr == ADDR_W'(OFS_LOCK)) begin
                locked_o <= (pwdata != UNLOCK_KEY);
            end else if (!locked_o) begin
                unique case (paddr)
                    ADDR_W'(OFS_LOAD): begin
                        load_o     <= pwdata;
                        load_tgl_o <= ~load_tgl_o;
                    end
                    ADDR_W'(OFS_CTRL): ctrl_o    <= pwdata[1:0];
                    ADDR_W'(OFS_CLR):  clr_tgl_o <= ~clr_tgl_o;
                    ADDR_W'(OFS_TCTL): tmode_o   <= pwdata[0];
                    ADDR_W'(OFS_TOUT): tout_o    <= pwdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        prdata = '0;
        unique case (paddr)
            ADDR_W'(OFS_LOAD): prdata = load_o;
            ADDR_W'(OFS_CTRL): prdata[1:0] = ctrl_o;
            ADDR_W'(OFS_RAW):  prdata[0] = raw_b;
            ADDR_W'(OFS_MASK): prdata[0] = raw_b & ctrl_o[0];
            ADDR_W'(OFS_LOCK): prdata[0] = locked_o;
            ADDR_W'(OFS_TCTL): prdata[0] = tmode_o;
            ADDR_W'(OFS_TOUT): prdata[1:0] = tout_o;
            default: ;
        endcase
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             wclk,
    input  logic             wresetn,
    input  logic [1:0]       ctrl_s,
    input  logic             load_tgl_s,
    input  logic             clr_tgl_s,
    input  logic [CNT_W-1:0] load_val,
    output logic             raw_o,
    output logic             irq_o,
    output logic             rst_o
);
    wd_state_t        state_q, state_n;
    logic [CNT_W-1:0] cnt_q;
    logic             load_prev, clr_prev;
    logic             ev_load, ev_clr, inten, resen, run, expire;

    assign inten   = ctrl_s[0];
    assign resen   = ctrl_s[1];
    assign ev_load = load_tgl_s ^ load_prev;
    assign ev_clr  = clr_tgl_s ^ clr_prev;
    assign run     = inten && (state_q != WD_TRIPPED);
    assign expire  = run && (cnt_q <= CNT_W'(1));

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (expire)     state_n = WD_EXPIRED;
                else if (inten) state_n = WD_ARMED;
            end
            WD_ARMED: begin
                if (expire)      state_n = WD_EXPIRED;
                else if (!inten) state_n = WD_IDLE;
            end
            WD_EXPIRED: begin
                if (ev_clr)               state_n = inten ? WD_ARMED : WD_IDLE;
                else if (expire && resen) state_n = WD_TRIPPED;
            end
            WD_TRIPPED: state_n = WD_TRIPPED;
            default:    state_n = WD_IDLE;
        endcase
    end

    // state register together with the counter it sequences
    always_ff @(posedge wclk or negedge wresetn) begin
        if (!wresetn) begin
            state_q   <= WD_IDLE;
            cnt_q     <= '1;
            load_prev <= 1'b0;
            clr_prev  <= 1'b0;
        end else begin
            state_q   <= state_n;
            load_prev <= load_tgl_s;
            clr_prev  <= clr_tgl_s;
            if (ev_load || expire || (ev_clr && state_q != WD_TRIPPED))
                cnt_q <= load_val;
            else if (run)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge wclk or negedge wresetn) begin
        if (!wresetn) begin
            raw_o <= 1'b0;
            irq_o <= 1'b0;
            rst_o <= 1'b0;
        end else begin
            raw_o <= (state_n == WD_EXPIRED) || (state_n == WD_TRIPPED);
            irq_o <= ((state_n == WD_EXPIRED) || (state_n == WD_TRIPPED)) && inten;
            rst_o <= (state_n == WD_TRIPPED);
        end
    end
endmodule

// File: rtl/apb_wdog.sv
module apb_wdog
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              wclk,
    input  logic              wresetn,
    output logic              wdog_irq,
    output logic              wdog_rst
);
    logic [1:0]        ctrl_q, ctrl_s, tout_q;
    logic [DATA_W-1:0] load_q;
    logic              load_tgl, clr_tgl, load_tgl_s, clr_tgl_s;
    logic              tmode_q, lock_q, raw_b;
    logic              core_raw, core_irq, core_rst;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .raw_b(raw_b), .ctrl_o(ctrl_q), .load_o(load_q),
        .load_tgl_o(load_tgl), .clr_tgl_o(clr_tgl), .tmode_o(tmode_q),
        .tout_o(tout_q), .locked_o(lock_q)
    );

    wdt_sync #(.W(4)) u_to_core (
        .clk(wclk), .rst_n(wresetn),
        .d({clr_tgl, load_tgl, ctrl_q}),
        .q({clr_tgl_s, load_tgl_s, ctrl_s})
    );

    wdt_sync #(.W(1)) u_to_bus (
        .clk(pclk), .rst_n(presetn), .d(core_raw), .q(raw_b)
    );

    wdt_core #(.CNT_W(DATA_W)) u_core (
        .wclk(wclk), .wresetn(wresetn), .ctrl_s(ctrl_s),
        .load_tgl_s(load_tgl_s), .clr_tgl_s(clr_tgl_s), .load_val(load_q),
        .raw_o(core_raw), .irq_o(core_irq), .rst_o(core_rst)
    );

    assign wdog_irq = tmode_q ? tout_q[0] : core_irq;
    assign wdog_rst = tmode_q ? tout_q[1] : core_rst;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              pclk,
    input logic              presetn,
    input logic              wclk,
    input logic              wresetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic [1:0]        ctrl_q,
    input logic [DATA_W-1:0] load_q,
    input logic              lock_q,
    input logic              core_raw,
    input logic              core_rst
);
    p_masked_zero_r5: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !pwrite && paddr == ADDR_W'(OFS_MASK) && !ctrl_q[0]) |-> (prdata == '0));

    p_key_unlocks_r9: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == ADDR_W'(OFS_LOCK) && pwdata == UNLOCK_KEY)
        |=> !lock_q);

    p_locked_load_hold_r10: assert property (@(posedge pclk) disable iff (!presetn)
        (lock_q && psel && penable && pwrite && paddr == ADDR_W'(OFS_LOAD))
        |=> $stable(load_q));

    p_trip_sticky_r7: assert property (@(posedge wclk) disable iff (!wresetn)
        core_rst |=> core_rst);

    p_trip_pending_r7: assert property (@(posedge wclk) disable iff (!wresetn)
        core_rst |-> core_raw);
endmodule

bind apb_wdog wdt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .pclk(pclk), .presetn(presetn), .wclk(wclk), .wresetn(wresetn),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .ctrl_q(ctrl_q), .load_q(load_q),
    .lock_q(lock_q), .core_raw(core_raw), .core_rst(core_rst)
);

// File: tb/test_apb_wdog.sv
`timescale 1ns/1ps
module test_apb_wdog;
    logic        pclk = 1'b0, wclk = 1'b0;
    logic        presetn = 1'b0, wresetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        wdog_irq, wdog_rst;
    int          n_cmp = 0, n_bad = 0;

    apb_wdog #(.ADDR_W(8)) i_apb_wdog (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .wclk(wclk), .wresetn(wresetn), .wdog_irq(wdog_irq), .wdog_rst(wdog_rst)
    );

    always #2 pclk = ~pclk;
    initial begin #1; forever #2 wclk = ~wclk; end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk); penable = 1; #1 d = prdata;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        check(v, exp, tag);
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge wclk);
    endtask

    task automatic do_reset();
        presetn = 0; wresetn = 0;
        repeat (4) @(negedge pclk);
        presetn = 1; wresetn = 1;
        repeat (2) @(negedge pclk);
    endtask

    task automatic t_reset();
        do_reset();
        rd_chk(8'h04, 32'h0, "R1 ctrl");
        rd_chk(8'h00, 32'hFFFF_FFFF, "R1 load");
        rd_chk(8'h14, 32'h0, "R1 lock");
        check({31'b0, wdog_irq}, 32'h0, "R1 irq");
        check({31'b0, wdog_rst}, 32'h0, "R1 rst");
    endtask

    task automatic t_regs();
        wr(8'h04, 32'h2); rd_chk(8'h04, 32'h2, "R2 ctrl resen only");
        wr(8'h04, 32'h1); rd_chk(8'h04, 32'h1, "R2 ctrl inten only");
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h1234_5678); rd_chk(8'h00, 32'h1234_5678, "R2 load readback");
    endtask

    task automatic t_count_clear();
        do_reset();
        wr(8'h00, 32'd40); wr(8'h04, 32'h1);
        wcyc(20); rd_chk(8'h0C, 32'h0, "R3 raw not early");
        wcyc(60); rd_chk(8'h0C, 32'h1, "R3 raw after period");
        check({31'b0, wdog_irq}, 32'h1, "R3 irq high");
        rd_chk(8'h10, 32'h1, "R5 masked set");
        wr(8'h04, 32'h0);
        rd_chk(8'h10, 32'h0, "R5 masked off when disabled");
        rd_chk(8'h0C, 32'h1, "R5 raw kept");
        wcyc(10); check({31'b0, wdog_irq}, 32'h0, "R5 irq dropped");
        wr(8'h04, 32'h1); wr(8'h08, 32'h0);
        wcyc(10); rd_chk(8'h0C, 32'h0, "R6 raw cleared");
        wcyc(60); rd_chk(8'h0C, 32'h1, "R6 raw back after reload");
    endtask

    task automatic t_hold();
        do_reset();
        wr(8'h00, 32'd20); wr(8'h04, 32'h0);
        wcyc(100); rd_chk(8'h0C, 32'h0, "R4 no count when disabled");
    endtask

    task automatic t_no_reset();
        wr(8'h04, 32'h1);
        wcyc(150); rd_chk(8'h0C, 32'h1, "R8 raw set");
        check({31'b0, wdog_rst}, 32'h0, "R8 rst stays low");
    endtask

    task automatic t_trip();
        do_reset();
        wr(8'h00, 32'd30); wr(8'h04, 32'h3);
        wcyc(120); check({31'b0, wdog_rst}, 32'h1, "R7 rst after second run-out");
        wr(8'h08, 32'h0);
        wcyc(10); check({31'b0, wdog_rst}, 32'h1, "R7 rst survives clear");
        @(negedge wclk); wresetn = 0; wcyc(2); wresetn = 1; wcyc(2);
        check({31'b0, wdog_rst}, 32'h0, "R7 rst dropped by counter reset");
    endtask

    task automatic t_lock();
        do_reset();
        wr(8'h14, 32'h0);  rd_chk(8'h14, 32'h1, "R9 locked reads 1");
        wr(8'h00, 32'h5);  rd_chk(8'h00, 32'hFFFF_FFFF, "R10 load ignored");
        wr(8'h04, 32'h3);  rd_chk(8'h04, 32'h0, "R10 ctrl ignored");
        wr(8'h14, 32'h1ACC_E550); rd_chk(8'h14, 32'h1, "R9 near key keeps lock");
        wr(8'h14, 32'h1ACC_E551); rd_chk(8'h14, 32'h0, "R9 key unlocks");
        wr(8'h04, 32'h1);  rd_chk(8'h04, 32'h1, "R9 write after unlock");
    endtask

    task automatic t_test_mode();
        do_reset();
        wr(8'h18, 32'h1); wr(8'h1C, 32'h3);
        check({30'b0, wdog_rst, wdog_irq}, 32'h3, "R11 both driven");
        wr(8'h1C, 32'h2);
        check({30'b0, wdog_rst, wdog_irq}, 32'h2, "R11 rst only");
        wr(8'h1C, 32'h3); wr(8'h18, 32'h0);
        check({30'b0, wdog_rst, wdog_irq}, 32'h0, "R12 back to counter");
    endtask

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_count_clear();
        t_hold();
        t_no_reset();
        t_trip();
        t_lock();
        t_test_mode();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule